// File: doc/BRIEF.md
# Memory Latency Configuration Sequencer

This block brings an external pseudo-static DRAM to a working initial-latency setting right after reset. It reads the system clock frequency from an input and takes the memory clock as one quarter of it. From that clock it picks an initial-latency cycle count and drives the count to the memory controller on a dedicated latency output. It then builds the device's configuration word and writes it through the controller's register-access request port. Finally it reads the same register back and compares it with what it wrote.

The request port has no data stream and no back-pressure. A request is a single-cycle pulse, with the address and data held steady on their own outputs. The sequencer waits for the matching level-sensitive done input before it moves on, so only one request is ever in flight. Each wait is bounded by a limit supplied on an input. If that limit runs out, the sequencer gives up, raises a timeout flag and issues nothing further. When readback completes, a sticky done flag rises, the read-back word is presented, and a mismatch flag shows whether that word differs from the written one.

Top module: `cfg_latency_sequencer`

## Requirements
- R1: While reset is held, every request pulse, done, mismatch and timeout output is 0, the address, write data and readback outputs are 0, and the latency output reads the safe value 7.
- R2: On the first clock edge after reset is released, the latency output takes its looked-up value. The first write pulse follows one cycle later, and the latency output does not change while any request is made.
- R3: The memory clock is floor(system frequency / 4) Hz. The latency is 3 cycles at or below 85 MHz, 4 at or below 104 MHz, 5 at or below 133 MHz, 6 at or below 166 MHz, and 7 above 166 MHz (including above 250 MHz).
- R4: The written word starts from 0x8F2F. Bits 7:4 are replaced by the device latency code: 1110, 1111, 0000, 0001 or 0010 for 3, 4, 5, 6 or 7 cycles. All other bits except bit 3 keep the template value.
- R5: Bit 3 of the written word is 0 when the variable-latency status input is 1, and 1 when that input is 0.
- R6: Exactly one write pulse is issued, one cycle wide, with address 2 and the composed word on the write-data output. The sequencer does not advance until the write-done input is seen high.
- R7: A write-done seen in the clock cycle after the write pulse's cycle N causes exactly one one-cycle read pulse, with address 2, in the cycle after that. No read is issued before write-done.
- R8: If read-done is first seen high in the cycle N cycles after the read pulse's cycle, the done flag is visible N+1 cycles after that pulse. The readback output then holds the read-data input captured in that cycle, and done stays high until reset with no further requests.
- R9: The mismatch flag is set together with done when the captured read data differs from the written word, and is 0 otherwise.
- R10: The write and read pulses are never high together, and neither is issued while the other is still waiting for its done input.
- R11: In each wait, let N be the number of cycles after the request cycle before its done input is seen. With a timeout limit L, N <= L proceeds normally. N > L sets the timeout flag in the cycle L+1 after the request. After that, no further requests are made, done stays 0, and the flag holds until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset; releasing it starts the sequence |
| sys_freq_hz | input | 32 | System clock frequency in Hz |
| var_lat_mode | input | 1 | Controller status: 1 = variable-latency mode |
| tmo_limit | input | 16 | Maximum wait cycles per request before giving up |
| ctrl_latency | output | 3 | Initial-latency cycle count for the controller |
| req_wr | output | 1 | One-cycle register write request |
| req_rd | output | 1 | One-cycle register read request |
| req_addr | output | 4 | Device register address of the request |
| req_wdata | output | 16 | Word to be written |
| wr_done | input | 1 | Controller status: write finished |
| rd_done | input | 1 | Controller status: read finished, rd_data valid |
| rd_data | input | 16 | Register read data |
| cfg_readback | output | 16 | Word captured from the readback |
| seq_done | output | 1 | Sticky: readback completed |
| seq_mismatch | output | 1 | Read-back word differs from the written word |
| seq_timeout | output | 1 | Sticky: a done input never arrived within the limit |

## Verification
The hardest situation to reach from the ports is the exact edge of the wait limit. That edge sits where a done input that arrives on the last permitted cycle must pass, and one that arrives a single cycle later must trip the timeout. It must also behave the same in both the write wait and the read wait. The bench acts as the controller and answers each request after a chosen delay. It sweeps delays of L and L+1 against a fixed limit in both waits, and a limit of zero with an immediate answer. The frequency sweep lands every lookup boundary on exact multiples of four plus offsets of 3 and 4 Hz, so the floor division is tested on both sides of each threshold.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

  typedef enum logic [2:0] {
    ST_LAT      = 3'd0,
    ST_WR_ISSUE = 3'd1,
    ST_WR_WAIT  = 3'd2,
    ST_RD_WAIT  = 3'd3,
    ST_DONE     = 3'd4,
    ST_HALT     = 3'd5
  } seq_state_t;

  localparam int LAT_STEPS = 4;
  localparam logic [2:0] LAT_MIN  = 3'd3;
  localparam logic [2:0] LAT_SAFE = 3'd7;

  // Upper memory-clock bound (Hz) of each latency step, lowest first.
  function automatic logic [31:0] lat_edge_hz(input int idx);
    case (idx)
      0:       lat_edge_hz = 32'd85_000_000;
      1:       lat_edge_hz = 32'd104_000_000;
      2:       lat_edge_hz = 32'd133_000_000;
      default: lat_edge_hz = 32'd166_000_000;
    endcase
  endfunction

endpackage

// File: rtl/cfgseq_lat_lookup.sv
module cfgseq_lat_lookup
  import cfgseq_pkg::*;
#(
  parameter int FREQ_W = 32
) (
  input  logic [FREQ_W-1:0] sys_freq_hz,
  output logic [2:0]        lat_cycles
);

  localparam int SHIFT = 2;

  logic [FREQ_W-1:0]    mem_hz;
  logic [LAT_STEPS-1:0] above;

  assign mem_hz = sys_freq_hz >> SHIFT;

  genvar gi;
  generate
    for (gi = 0; gi < LAT_STEPS; gi++) begin : g_step
      assign above[gi] = ({32'd0, mem_hz} > {{FREQ_W{1'b0}}, lat_edge_hz(gi)});
    end
  endgenerate

  always_comb begin
    lat_cycles = LAT_MIN;
    for (int k = 0; k < LAT_STEPS; k++) begin
      if (above[k]) lat_cycles = lat_cycles + 3'd1;
    end
  end

endmodule

// File: rtl/cfgseq_word_builder.sv
module cfgseq_word_builder #(
  parameter int                DATA_W   = 16,
  parameter logic [DATA_W-1:0] TEMPLATE = 16'h8F2F
) (
  input  logic [2:0]        lat_cycles,
  input  logic              var_mode,
  output logic [DATA_W-1:0] cfg_word
);

  localparam int CODE_LSB = 4;
  localparam int CODE_W   = 4;
  localparam int MODE_BIT = 3;

  logic [CODE_W-1:0] dev_code;

  // Device code is the cycle count minus five, wrapping in four bits.
  assign dev_code = {1'b0, lat_cycles} - 4'd5;

  always_comb begin
    cfg_word = TEMPLATE;
    cfg_word[CODE_LSB +: CODE_W] = dev_code;
    cfg_word[MODE_BIT] = TEMPLATE[MODE_BIT] & ~var_mode;
  end

endmodule

// File: rtl/cfgseq_wait_timer.sv
module cfgseq_wait_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);

  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (run && (cnt != limit)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired = run && (cnt == limit);

  AST_TMR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0)) else $error("timer not restarted"); // R11

endmodule

// File: rtl/cfg_latency_sequencer.sv
module cfg_latency_sequencer
  import cfgseq_pkg::*;
#(
  parameter int                FREQ_W       = 32,
  parameter int                DATA_W       = 16,
  parameter int                ADDR_W       = 4,
  parameter int                TMO_W        = 16,
  parameter logic [ADDR_W-1:0] CFG_ADDR     = 4'd2,
  parameter logic [DATA_W-1:0] CFG_TEMPLATE = 16'h8F2F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FREQ_W-1:0] sys_freq_hz,
  input  logic              var_lat_mode,
  input  logic [TMO_W-1:0]  tmo_limit,
  output logic [2:0]        ctrl_latency,
  output logic              req_wr,
  output logic              req_rd,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              wr_done,
  input  logic              rd_done,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] cfg_readback,
  output logic              seq_done,
  output logic              seq_mismatch,
  output logic              seq_timeout
);

  seq_state_t        state;
  logic [2:0]        lat_lookup;
  logic [DATA_W-1:0] cfg_word;
  logic              tmr_clear;
  logic              tmr_run;
  logic              tmr_expired;

  cfgseq_lat_lookup #(.FREQ_W(FREQ_W)) u_lookup (
    .sys_freq_hz (sys_freq_hz),
    .lat_cycles  (lat_lookup)
  );

  cfgseq_word_builder #(.DATA_W(DATA_W), .TEMPLATE(CFG_TEMPLATE)) u_word (
    .lat_cycles (ctrl_latency),
    .var_mode   (var_lat_mode),
    .cfg_word   (cfg_word)
  );

  assign tmr_clear = (state == ST_WR_ISSUE) || ((state == ST_WR_WAIT) && wr_done);
  assign tmr_run   = ((state == ST_WR_WAIT) && !wr_done) ||
                     ((state == ST_RD_WAIT) && !rd_done);

  cfgseq_wait_timer #(.TMO_W(TMO_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (tmr_clear),
    .run     (tmr_run),
    .limit   (tmo_limit),
    .expired (tmr_expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_LAT;
      ctrl_latency <= LAT_SAFE;
      req_wr       <= 1'b0;
      req_rd       <= 1'b0;
      req_addr     <= '0;
      req_wdata    <= '0;
      cfg_readback <= '0;
      seq_done     <= 1'b0;
      seq_mismatch <= 1'b0;
      seq_timeout  <= 1'b0;
    end else begin
      req_wr <= 1'b0;
      req_rd <= 1'b0;
      case (state)
        ST_LAT: begin
          ctrl_latency <= lat_lookup;
          state        <= ST_WR_ISSUE;
        end
        ST_WR_ISSUE: begin
          req_wdata <= cfg_word;
          req_addr  <= CFG_ADDR;
          req_wr    <= 1'b1;
          state     <= ST_WR_WAIT;
        end
        ST_WR_WAIT: begin
          if (wr_done) begin
            req_rd <= 1'b1;
            state  <= ST_RD_WAIT;
          end else if (tmr_expired) begin
            seq_timeout <= 1'b1;
            state       <= ST_HALT;
          end
        end
        ST_RD_WAIT: begin
          if (rd_done) begin
            cfg_readback <= rd_data;
            seq_mismatch <= (rd_data != req_wdata);
            seq_done     <= 1'b1;
            state        <= ST_DONE;
          end else if (tmr_expired) begin
            seq_timeout <= 1'b1;
            state       <= ST_HALT;
          end
        end
        default: state <= state;
      endcase
    end
  end

  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_wr && req_rd)) else $error("both requests high"); // R10
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_wr |=> !req_wr) else $error("write pulse too wide"); // R6
  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_rd |=> !req_rd) else $error("read pulse too wide"); // R7
  AST_LAT_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr || req_rd) |-> (ctrl_latency >= LAT_MIN) && $stable(ctrl_latency))
    else $error("latency moving during request"); // R2
  AST_REQ_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr || req_rd) |-> (req_addr == CFG_ADDR)) else $error("bad address"); // R6
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> seq_done) else $error("done dropped"); // R8
  AST_TMO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    seq_timeout |=> seq_timeout) else $error("timeout dropped"); // R11
  AST_END_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done || seq_timeout) |-> !req_wr && !req_rd) else $error("request after end"); // R11
  AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_done && seq_timeout)) else $error("done and timeout"); // R11

endmodule

// File: tb/sim_cfg_latency_sequencer.sv
module sim_cfg_latency_sequencer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] sys_freq_hz = '0;
  logic        var_lat_mode = 1'b0;
  logic [15:0] tmo_limit = 16'd8;
  logic [2:0]  ctrl_latency;
  logic        req_wr, req_rd;
  logic [3:0]  req_addr;
  logic [15:0] req_wdata;
  logic        wr_done = 1'b0;
  logic        rd_done = 1'b0;
  logic [15:0] rd_data = '0;
  logic [15:0] cfg_readback;
  logic        seq_done, seq_mismatch, seq_timeout;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cfg_latency_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .sys_freq_hz(sys_freq_hz), .var_lat_mode(var_lat_mode),
    .tmo_limit(tmo_limit), .ctrl_latency(ctrl_latency), .req_wr(req_wr), .req_rd(req_rd),
    .req_addr(req_addr), .req_wdata(req_wdata), .wr_done(wr_done), .rd_done(rd_done),
    .rd_data(rd_data), .cfg_readback(cfg_readback), .seq_done(seq_done),
    .seq_mismatch(seq_mismatch), .seq_timeout(seq_timeout)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_lat(input logic [31:0] f);
    longint m;
    m = longint'(f) / 4;
    if (m <= 85_000_000) return 3;
    if (m <= 104_000_000) return 4;
    if (m <= 133_000_000) return 5;
    if (m <= 166_000_000) return 6;
    return 7;
  endfunction

  function automatic logic [15:0] exp_word(input int lat, input logic v);
    logic [3:0] code;
    logic [15:0] w;
    case (lat)
      3: code = 4'b1110;
      4: code = 4'b1111;
      5: code = 4'b0000;
      6: code = 4'b0001;
      default: code = 4'b0010;
    endcase
    w = 16'h8F2F;
    w[7:4] = code;
    w[3] = v ? 1'b0 : 1'b1;
    return w;
  endfunction

  // err_at: 0 none expected, 1 write wait times out, 2 read wait times out
  task automatic run_case(input logic [31:0] f, input logic v, input int wdly, input int rdly,
                          input logic corrupt, input logic [15:0] lim, input int err_at);
    int lat_e, nwr, nrd, wpend, rpend, since, t_end, overlap;
    bit wr_open, rd_open, lat_moved;
    logic [15:0] w_e, cap;
    lat_e = exp_lat(f);
    w_e = exp_word(lat_e, v);
    nwr = 0; nrd = 0; wpend = -1; rpend = -1; since = -1; t_end = -1; overlap = 0;
    wr_open = 0; rd_open = 0; lat_moved = 0; cap = '0;
    rst_n = 1'b0; wr_done = 1'b0; rd_done = 1'b0; rd_data = '0;
    sys_freq_hz = f; var_lat_mode = v; tmo_limit = lim;
    repeat (3) @(negedge clk);
    check(!req_wr && !req_rd && !seq_done && !seq_mismatch && !seq_timeout &&
          req_addr == 0 && req_wdata == 0 && cfg_readback == 0, "R1", "reset outputs",
          {req_wr, req_rd, seq_done, seq_mismatch, seq_timeout}, 0);
    check(ctrl_latency == 3'd7, "R1", "reset latency", ctrl_latency, 7);
    rst_n = 1'b1;
    @(negedge clk);
    check(ctrl_latency == 3'(lat_e) && !req_wr, "R2", "latency first cycle", ctrl_latency, lat_e);
    check(int'(ctrl_latency) == lat_e, "R3", $sformatf("lookup f=%0d", f), ctrl_latency, lat_e);
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      wr_done = 1'b0; rd_done = 1'b0;
      if (since >= 0) since++;
      if ((seq_done || seq_timeout) && t_end < 0) t_end = since;
      if (req_wr || req_rd) begin
        if (wr_open || rd_open || (req_wr && req_rd)) overlap++;
        if (int'(ctrl_latency) != lat_e) lat_moved = 1;
        if (req_addr != 4'd2) overlap++;
        since = 0;
      end
      if (req_wr) begin
        nwr++; cap = req_wdata; wr_open = 1; wpend = wdly;
      end
      if (req_rd) begin
        nrd++; rd_open = 1; rpend = rdly;
      end
      if (wpend == 0) begin
        wr_done = 1'b1; wr_open = 0; wpend = -1;
      end else if (wpend > 0) wpend--;
      if (rpend == 0) begin
        rd_done = 1'b1; rd_open = 0; rpend = -1;
        rd_data = corrupt ? (cap ^ 16'h0100) : cap;
      end else if (rpend > 0) rpend--;
    end
    wr_done = 1'b0; rd_done = 1'b0;
    check(!lat_moved, "R2", "latency stable at requests", lat_moved, 0);
    check(overlap == 0, "R10", "overlap or bad address", overlap, 0);
    check(nwr == 1, "R6", "write count", nwr, 1);
    check(cap == w_e, "R4", "written word", cap, w_e);
    check(cap[3] == !v, "R5", "mode bit", cap[3], !v);
    if (err_at == 0) begin
      check(nrd == 1, "R7", "read count", nrd, 1);
      check(seq_done && !seq_timeout, "R8", "done set", {seq_done, seq_timeout}, 2);
      check(t_end == rdly + 1, "R8", "done timing", t_end, rdly + 1);
      check(cfg_readback == (corrupt ? (w_e ^ 16'h0100) : w_e), "R8", "readback",
            cfg_readback, corrupt ? (w_e ^ 16'h0100) : w_e);
      check(seq_mismatch == corrupt, "R9", "mismatch", seq_mismatch, corrupt);
    end else begin
      check(nrd == (err_at == 2 ? 1 : 0), "R11", "reads before timeout", nrd, err_at == 2 ? 1 : 0);
      check(seq_timeout && !seq_done, "R11", "timeout flag", {seq_done, seq_timeout}, 1);
      check(t_end == int'(lim) + 1, "R11", "timeout timing", t_end, int'(lim) + 1);
    end
  endtask

  initial begin
    int bnd[5];
    int k;
    logic [31:0] pts[17];
    bnd[0] = 85_000_000; bnd[1] = 104_000_000; bnd[2] = 133_000_000;
    bnd[3] = 166_000_000; bnd[4] = 250_000_000;
    k = 0;
    for (int b = 0; b < 5; b++) begin
      pts[k] = 32'(4 * longint'(bnd[b]));     k++;
      pts[k] = 32'(4 * longint'(bnd[b]) + 3); k++;
      pts[k] = 32'(4 * longint'(bnd[b]) + 4); k++;
    end
    pts[15] = 32'd0;
    pts[16] = 32'hFFFF_FFFF;
    for (int i = 0; i < 17; i++) begin
      for (int v = 0; v < 2; v++) begin
        run_case(pts[i], v[0], i % 3, (i + v) % 4, 1'b0, 16'd8, 0);
      end
    end
    run_case(32'd400_000_000, 1'b1, 1, 2, 1'b1, 16'd8, 0);   // R9 corrupted readback
    run_case(32'd500_000_000, 1'b0, 5, 5, 1'b0, 16'd5, 0);   // R11 answer on last allowed cycle
    run_case(32'd500_000_000, 1'b0, 6, 0, 1'b0, 16'd5, 1);   // R11 write one cycle late
    run_case(32'd600_000_000, 1'b1, 0, 6, 1'b0, 16'd5, 2);   // R11 read one cycle late
    run_case(32'd300_000_000, 1'b0, 0, 0, 1'b0, 16'd0, 0);   // R11 zero limit, instant answer
    run_case(32'd300_000_000, 1'b0, 1, 0, 1'b0, 16'd0, 1);   // R11 zero limit, late write
    run_case(32'd700_000_000, 1'b1, 999, 0, 1'b0, 16'd20, 1); // R11 controller never answers
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 150000; w++) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule